// File: doc/BRIEF.md
# SAR ADC Controller Register Front End

This block is the bus-facing register file of a successive-approximation ADC controller that converts one input at a time. A host issues word-aligned reads and writes over a simple valid/write bus. Writing a channel number to the primary channel-control word starts a conversion. Writing the all-ones channel code stops the converter. The analog converter sits outside the block. The block hands it a one-cycle start pulse with the channel, and gets back a done strobe with the sample.

Finished samples are held in a result word that is masked to the selected resolution. A completion flag marks each sample. An interrupt line is raised when the flag is set and the interrupt-enable bit is set. A continuous-conversion bit restarts the same channel after every sample. An overwrite-enable bit decides whether a fresh sample replaces one that has not been read yet. A calibration request is sent to the engine by writing the calibration bit. That bit clears itself when the engine reports completion, and the engine's pass/fail verdict is kept in the general status word.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After synchronous reset, every register reads zero, irq is low, and conv_start and cal_start are low.
- R2: A write to offset 0x00 whose bits [4:0] are not 0x1F, made while no calibration runs, stores bits [7:0]. In the next cycle it gives a one-cycle conv_start pulse, with conv_chan equal to the written bits [4:0].
- R3: A write of channel code 0x1F to offset 0x00 starts nothing and stops the converter. Any conv_done that arrives while the converter is stopped is ignored: the flag and the result do not change.
- R4: A conv_done received while a conversion is active sets the completion flag (offset 0x08 bit 0). A read of the result word at offset 0x0C clears the flag.
- R5: The overwrite enable is configuration bit 16 (offset 0x14). When it is set, a new sample replaces an unread one. When it is clear and the flag is set, the stored sample is kept. A sample read in the same cycle counts as read.
- R6: Offset 0x0C returns the stored sample masked by configuration bits [3:2]: 00 keeps 8 bits, 01 keeps 10 bits, 10 or 11 keep 12 bits.
- R7: irq is high exactly when the completion flag is set and channel-control bit 7 is set.
- R8: When general-control bit 6 (offset 0x18) is set, each accepted conv_done issues a new conv_start on the same channel in the next cycle. When it is clear, a conversion ends after one sample.
- R9: Writing 1 to general-control bit 7 gives a one-cycle cal_start pulse in the next cycle and sets the channel-control word to 0x9F. Bit 7 then reads 1 until cal_done. cal_done clears bit 7, sets the completion flag, and copies cal_fail into general-status bit 1 (offset 0x1C).
- R10: An access that is not word-aligned, or that targets an unused offset (0x2C or anything above 0x30), has no effect and reads zero. Offsets 0x04, 0x20, 0x24, 0x28 and 0x30 are plain read/write storage.
- R11: Every read request produces rd_valid with its data exactly one cycle later.
- R12: While a calibration runs, writes to offset 0x00 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| conv_start | output | 1 | One-cycle conversion start to the engine |
| conv_chan | output | 5 | Channel for the conversion |
| conv_done | input | 1 | Engine finished a sample |
| conv_result | input | 12 | Sample from the engine |
| cal_start | output | 1 | One-cycle calibration start to the engine |
| cal_done | input | 1 | Engine finished calibration |
| cal_fail | input | 1 | Calibration verdict, valid with cal_done |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The hardest situations to reach from the ports are a sample that lands on an unread result, and a done strobe that arrives after the converter has been stopped. The bench acts as the conversion engine, so it decides when each done strobe lands. It sends two samples with no read between them, once with overwrite off and once with it on. It stops a continuous run with the 0x1F code before sending one more done. It also writes the channel word in the middle of a calibration and reads the word back, which shows that the write was dropped.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

    parameter int ADDR_W    = 8;
    parameter int DATA_W    = 32;
    parameter int CH_W      = 5;
    parameter int SMP_W     = 12;
    parameter int CTL_W     = 8;
    parameter int CFG_W     = 17;
    parameter int NUM_PLAIN = 4;

    localparam logic [CH_W-1:0] CH_STOP = {CH_W{1'b1}};
    localparam int CH_IE_BIT   = 7;
    localparam int GC_CONT_BIT = 6;
    localparam int GC_CAL_BIT  = 7;
    localparam int CFG_OVW_BIT = 16;
    localparam int CFG_RES_LSB = 2;
    localparam int GS_CALF_BIT = 1;
    localparam int ST_DONE_BIT = 0;

    typedef enum logic [3:0] {
        REG_CH0, REG_CH1, REG_STAT, REG_RES0, REG_RES1, REG_CFG,
        REG_GCTL, REG_GSTAT, REG_CMP, REG_OFS, REG_CALV, REG_PIN, REG_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
        reg_sel_e s;
        s = REG_NONE;
        if (addr[1:0] == 2'b00) begin
            case (int'(addr >> 2))
                0:  s = REG_CH0;
                1:  s = REG_CH1;
                2:  s = REG_STAT;
                3:  s = REG_RES0;
                4:  s = REG_RES1;
                5:  s = REG_CFG;
                6:  s = REG_GCTL;
                7:  s = REG_GSTAT;
                8:  s = REG_CMP;
                9:  s = REG_OFS;
                10: s = REG_CALV;
                12: s = REG_PIN;
                default: s = REG_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic reg_sel_e plain_sel(input int idx);
        reg_sel_e s;
        case (idx)
            0:       s = REG_CMP;
            1:       s = REG_OFS;
            2:       s = REG_CALV;
            3:       s = REG_PIN;
            default: s = REG_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [SMP_W-1:0] width_mask(input logic [1:0] mode);
        logic [SMP_W-1:0] m;
        m = '1;
        case (mode)
            2'b00:   m = m >> (SMP_W - 8);
            2'b01:   m = m >> (SMP_W - 10);
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [CTL_W-1:0] cal_ch_word();
        logic [CTL_W-1:0] v;
        v = '0;
        v[CH_W-1:0] = CH_STOP;
        v[CH_IE_BIT] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
    import adc_regs_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_req_t          req
);
    always_comb begin
        req.rd    = bus_valid & ~bus_write;
        req.wr    = bus_valid & bus_write;
        req.sel   = decode_addr(bus_addr);
        req.wdata = bus_wdata;
    end
endmodule

// File: rtl/adc_plain_regs.sv
module adc_plain_regs
    import adc_regs_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  bus_req_t                          req,
    output logic [CTL_W-1:0]                  ch1_q,
    output logic [CFG_W-1:0]                  cfg_q,
    output logic [NUM_PLAIN-1:0][DATA_W-1:0]  plain_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ch1_q <= '0;
            cfg_q <= '0;
        end else if (req.wr) begin
            if (req.sel == REG_CH1) ch1_q <= req.wdata[CTL_W-1:0];
            if (req.sel == REG_CFG) cfg_q <= req.wdata[CFG_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (req.wr && req.sel == plain_sel(g)) begin
                word_q <= req.wdata;
            end
        end
        assign plain_q[g] = word_q;
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              ovw_en,
    input  logic              conv_done,
    input  logic [SMP_W-1:0]  conv_result,
    input  logic              cal_done,
    input  logic              cal_fail,
    output logic [CTL_W-1:0]  ch0_q,
    output logic [CTL_W-1:0]  gctl_q,
    output logic              flag_q,
    output logic [SMP_W-1:0]  result_q,
    output logic              calf_q,
    output logic              active_q,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic              cal_start,
    output logic              irq
);
    logic wr_ch0, wr_gctl, rd_res, cal_busy, take_smp, unread;
    logic [CH_W-1:0] wr_chan;

    always_comb begin
        wr_ch0   = req.wr && req.sel == REG_CH0;
        wr_gctl  = req.wr && req.sel == REG_GCTL;
        rd_res   = req.rd && req.sel == REG_RES0;
        cal_busy = gctl_q[GC_CAL_BIT];
        wr_chan  = req.wdata[CH_W-1:0];
        take_smp = conv_done && active_q;
        unread   = flag_q && !rd_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch0_q      <= '0;
            gctl_q     <= '0;
            flag_q     <= 1'b0;
            result_q   <= '0;
            calf_q     <= 1'b0;
            active_q   <= 1'b0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
            cal_start  <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            cal_start  <= 1'b0;

            if (rd_res) flag_q <= 1'b0;

            if (take_smp) begin
                flag_q <= 1'b1;
                if (!unread || ovw_en) result_q <= conv_result;
            end

            if (wr_ch0 && !cal_busy) begin
                ch0_q <= req.wdata[CTL_W-1:0];
                if (wr_chan == CH_STOP) begin
                    active_q <= 1'b0;
                end else begin
                    active_q   <= 1'b1;
                    conv_start <= 1'b1;
                    conv_chan  <= wr_chan;
                end
            end else if (take_smp) begin
                if (gctl_q[GC_CONT_BIT]) begin
                    conv_start <= 1'b1;
                    conv_chan  <= ch0_q[CH_W-1:0];
                end else begin
                    active_q <= 1'b0;
                end
            end

            if (wr_gctl) begin
                for (int b = 0; b < CTL_W; b++) begin
                    if (b != GC_CAL_BIT) gctl_q[b] <= req.wdata[b];
                end
                if (req.wdata[GC_CAL_BIT] && !cal_busy) begin
                    gctl_q[GC_CAL_BIT] <= 1'b1;
                    cal_start          <= 1'b1;
                    ch0_q              <= cal_ch_word();
                    active_q           <= 1'b0;
                    calf_q             <= 1'b0;
                end
            end else if (cal_done && cal_busy) begin
                gctl_q[GC_CAL_BIT] <= 1'b0;
                flag_q             <= 1'b1;
                calf_q             <= cal_fail;
            end
        end
    end

    assign irq = flag_q & ch0_q[CH_IE_BIT];
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [SMP_W-1:0]  conv_result,
    output logic              cal_start,
    input  logic              cal_done,
    input  logic              cal_fail,
    output logic              irq
);
    bus_req_t                         req;
    logic [CTL_W-1:0]                 ch0_q, ch1_q, gctl_q;
    logic [CFG_W-1:0]                 cfg_q;
    logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;
    logic                             flag_q, calf_q, active_q, cal_busy;
    logic [SMP_W-1:0]                 result_q;
    logic [DATA_W-1:0]                rmux;

    adc_bus_decode u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req       (req)
    );

    adc_plain_regs u_plain (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .ch1_q   (ch1_q),
        .cfg_q   (cfg_q),
        .plain_q (plain_q)
    );

    adc_conv_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .ovw_en      (cfg_q[CFG_OVW_BIT]),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .cal_done    (cal_done),
        .cal_fail    (cal_fail),
        .ch0_q       (ch0_q),
        .gctl_q      (gctl_q),
        .flag_q      (flag_q),
        .result_q    (result_q),
        .calf_q      (calf_q),
        .active_q    (active_q),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .cal_start   (cal_start),
        .irq         (irq)
    );

    assign cal_busy = gctl_q[GC_CAL_BIT];

    always_comb begin
        rmux = '0;
        case (req.sel)
            REG_CH0:   rmux = DATA_W'(ch0_q);
            REG_CH1:   rmux = DATA_W'(ch1_q);
            REG_STAT:  rmux[ST_DONE_BIT] = flag_q;
            REG_RES0:  rmux = DATA_W'(result_q & width_mask(cfg_q[CFG_RES_LSB +: 2]));
            REG_CFG:   rmux = DATA_W'(cfg_q);
            REG_GCTL:  rmux = DATA_W'(gctl_q);
            REG_GSTAT: rmux[GS_CALF_BIT] = calf_q;
            REG_CMP:   rmux = plain_q[0];
            REG_OFS:   rmux = plain_q[1];
            REG_CALV:  rmux = plain_q[2];
            REG_PIN:   rmux = plain_q[3];
            default:   rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req.rd;
            rd_data  <= req.rd ? rmux : '0;
        end
    end
endmodule

// File: rtl/adc_ctrl_regs_chk.sv
module adc_ctrl_regs_chk
    import adc_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              conv_start,
    input logic [CH_W-1:0]   conv_chan,
    input logic              conv_done,
    input logic              cal_start,
    input logic              irq,
    input logic              flag_q,
    input logic              active_q,
    input logic              cal_busy
);
    logic wr0, wrg, bad_rd;
    assign wr0    = bus_valid && bus_write && bus_addr == '0;
    assign wrg    = bus_valid && bus_write && bus_addr == ADDR_W'(8'h18);
    assign bad_rd = bus_valid && !bus_write &&
                    (bus_addr[1:0] != 2'b00 || bus_addr > ADDR_W'(8'h30) || bus_addr == ADDR_W'(8'h2C));

    assert_start_on_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr0 && bus_wdata[CH_W-1:0] != CH_STOP && !cal_busy)
        |=> (conv_start && conv_chan == $past(bus_wdata[CH_W-1:0])));

    assert_stop_no_start_R3: assert property (@(posedge clk) disable iff (rst)
        (wr0 && bus_wdata[CH_W-1:0] == CH_STOP) |=> !conv_start);

    assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (conv_done && active_q) |=> flag_q);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q);

    assert_cal_launch_R9: assert property (@(posedge clk) disable iff (rst)
        (wrg && bus_wdata[GC_CAL_BIT] && !cal_busy) |=> (cal_start && cal_busy));

    assert_bad_addr_zero_R10: assert property (@(posedge clk) disable iff (rst)
        bad_rd |=> (rd_valid && rd_data == '0));

    assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> rd_valid);

    assert_cal_blocks_write_R12: assert property (@(posedge clk) disable iff (rst)
        (wr0 && cal_busy) |=> !conv_start);
endmodule

bind adc_ctrl_regs adc_ctrl_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .cal_start  (cal_start),
    .irq        (irq),
    .flag_q     (flag_q),
    .active_q   (active_q),
    .cal_busy   (cal_busy)
);

// File: tb/test_adc_ctrl_regs.sv
module test_adc_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        conv_start;
    logic [4:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        cal_start;
    logic        cal_done = 1'b0, cal_fail = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    adc_ctrl_regs i_adc_ctrl_regs (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result), .cal_start(cal_start),
        .cal_done(cal_done), .cal_fail(cal_fail), .irq(irq)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write_t(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_read_t(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        check(rd_valid == 1'b1, "R11 rd_valid one cycle after read", 32'(rd_valid), 32'd1);
    endtask

    task automatic engine_done(input logic [11:0] r);
        @(negedge clk);
        conv_done = 1'b1; conv_result = r;
        @(posedge clk);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic engine_cal(input logic f);
        @(negedge clk);
        cal_done = 1'b1; cal_fail = f;
        @(posedge clk);
        @(negedge clk);
        cal_done = 1'b0; cal_fail = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        logic [31:0] e;
        string t;
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected rd_valid", 32'(rd_valid), 32'd0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'd0);
        check(conv_start == 1'b0 && cal_start == 1'b0, "R1 starts low", 32'(conv_start), 32'd0);
        bus_read_t(8'h08, 32'h0, "R1 status reset");
        bus_read_t(8'h00, 32'h0, "R1 channel word reset");
        bus_read_t(8'h14, 32'h0, "R1 config reset");
        bus_read_t(8'h18, 32'h0, "R1 general control reset");

        // R2 start conversion on channel 3 with interrupt enabled
        bus_write_t(8'h00, 32'h83);
        check(conv_start == 1'b1, "R2 start pulse", 32'(conv_start), 32'd1);
        check(conv_chan == 5'd3, "R2 start channel", 32'(conv_chan), 32'd3);
        @(negedge clk);
        check(conv_start == 1'b0, "R2 pulse one cycle", 32'(conv_start), 32'd0);

        // R4/R7/R6 sample arrives
        engine_done(12'hABC);
        check(irq == 1'b1, "R7 irq with flag and enable", 32'(irq), 32'd1);
        bus_read_t(8'h08, 32'h1, "R4 flag set");
        bus_read_t(8'h0C, 32'hBC, "R6 8-bit mask");
        bus_read_t(8'h08, 32'h0, "R4 flag cleared by result read");
        check(irq == 1'b0, "R7 irq low after read", 32'(irq), 32'd0);
        bus_write_t(8'h14, 32'h4);
        bus_read_t(8'h0C, 32'h2BC, "R6 10-bit mask");
        bus_write_t(8'h14, 32'h8);
        bus_read_t(8'h0C, 32'hABC, "R6 12-bit mask");

        // R5 overwrite disabled
        bus_write_t(8'h00, 32'h02);
        engine_done(12'h111);
        check(irq == 1'b0, "R7 irq low when disabled", 32'(irq), 32'd0);
        bus_write_t(8'h00, 32'h02);
        engine_done(12'h222);
        bus_read_t(8'h0C, 32'h111, "R5 unread sample kept");
        // R5 overwrite enabled
        bus_write_t(8'h14, 32'h10008);
        bus_write_t(8'h00, 32'h02);
        engine_done(12'h333);
        bus_write_t(8'h00, 32'h02);
        engine_done(12'h444);
        bus_read_t(8'h0C, 32'h444, "R5 unread sample replaced");

        // R3 stop code
        bus_write_t(8'h00, 32'h1F);
        check(conv_start == 1'b0, "R3 no start on stop code", 32'(conv_start), 32'd0);
        engine_done(12'h555);
        bus_read_t(8'h08, 32'h0, "R3 done ignored when stopped");
        bus_read_t(8'h0C, 32'h444, "R3 result unchanged when stopped");

        // R8 continuous
        bus_write_t(8'h18, 32'h40);
        bus_write_t(8'h00, 32'h05);
        check(conv_start == 1'b1 && conv_chan == 5'd5, "R8 first start", 32'(conv_chan), 32'd5);
        engine_done(12'h010);
        check(conv_start == 1'b1 && conv_chan == 5'd5, "R8 restart after sample", 32'(conv_start), 32'd1);
        engine_done(12'h020);
        check(conv_start == 1'b1, "R8 second restart", 32'(conv_start), 32'd1);
        bus_write_t(8'h00, 32'h1F);
        check(conv_start == 1'b0, "R3 stop ends continuous run", 32'(conv_start), 32'd0);
        engine_done(12'h030);
        check(conv_start == 1'b0, "R8 no restart after stop", 32'(conv_start), 32'd0);
        bus_read_t(8'h0C, 32'h020, "R3 late done ignored");
        bus_write_t(8'h18, 32'h00);
        bus_write_t(8'h00, 32'h05);
        engine_done(12'h066);
        check(conv_start == 1'b0, "R8 single mode no restart", 32'(conv_start), 32'd0);
        bus_read_t(8'h0C, 32'h066, "R8 single sample stored");

        // R9/R12 calibration
        bus_write_t(8'h18, 32'h80);
        check(cal_start == 1'b1, "R9 calibration pulse", 32'(cal_start), 32'd1);
        bus_read_t(8'h00, 32'h9F, "R9 channel word forced");
        bus_read_t(8'h18, 32'h80, "R9 calibrate bit held");
        bus_write_t(8'h00, 32'h03);
        check(conv_start == 1'b0, "R12 no start during calibration", 32'(conv_start), 32'd0);
        bus_read_t(8'h00, 32'h9F, "R12 channel write ignored");
        engine_cal(1'b1);
        check(irq == 1'b1, "R9 irq on calibration end", 32'(irq), 32'd1);
        bus_read_t(8'h18, 32'h00, "R9 calibrate bit self-clears");
        bus_read_t(8'h1C, 32'h2, "R9 failure reported");
        bus_read_t(8'h08, 32'h1, "R9 completion flag set");
        bus_read_t(8'h0C, 32'h066, "R9 result untouched");
        bus_write_t(8'h18, 32'h80);
        engine_cal(1'b0);
        bus_read_t(8'h1C, 32'h0, "R9 pass reported");
        bus_read_t(8'h0C, 32'h066, "R4 clear flag");

        // R10 decode
        bus_write_t(8'h24, 32'hDEADBEEF);
        bus_write_t(8'h26, 32'h0);
        bus_write_t(8'h16, 32'h0);
        bus_write_t(8'h2C, 32'h1234);
        bus_write_t(8'h34, 32'h5678);
        bus_write_t(8'h04, 32'h07);
        bus_write_t(8'h30, 32'hA5A5);
        bus_read_t(8'h24, 32'hDEADBEEF, "R10 plain storage");
        bus_read_t(8'h14, 32'h10008, "R10 misaligned write no effect");
        bus_read_t(8'h15, 32'h0, "R10 misaligned read zero");
        bus_read_t(8'h2C, 32'h0, "R10 unused offset zero");
        bus_read_t(8'h34, 32'h0, "R10 above range zero");
        bus_read_t(8'h04, 32'h07, "R10 second channel storage");
        bus_read_t(8'h30, 32'hA5A5, "R10 last offset storage");
        bus_read_t(8'h08, 32'h0, "R10 status unaffected");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule